// File: doc/BRIEF.md
# Transfer Count and Completion Unit

This unit keeps the byte count for a SCSI controller's data moves. The count can be moved by DMA or byte by byte by the host. The host sets up a start count by writing byte-wide lanes of a program register. When a DMA command is accepted, that value is copied into a live down-counter. The live counter can be read back at any time. Each byte moved while a DMA command runs takes one off the live counter. The unit keeps a terminal-count flag that shows the counter has run out.

While a command is active, the unit watches for its end. The end condition depends on the kind of transfer:

- DMA toward the host ends when the counter is zero.
- DMA toward the bus also waits for the FIFO occupancy, which is an input, to fall to zero.
- A host-driven transfer toward the bus ends when the FIFO is empty.
- A host-driven transfer from the bus ends on each single received byte.

When a command ends, the unit gives a one-cycle done pulse. On that same cycle it drops the DMA request and sets the DMA direction back to none.

Top module: `xfer_count_ctl`

## Requirements
- R1: A write with `cnt_wr_en[0]` set loads `cnt_wr_data` into bits 7:0 of the program register. A write with `cnt_wr_en[1]` set loads bits 15:8. The bits that are not written keep their value. After reset the program register holds 0.
- R2: `live_count` always shows the live counter, not the program register. It is 0 after reset. Writes to the program register leave it unchanged.
- R3: When `cmd_start` is high with `cmd_dma` high and the unit idle, the live counter takes the program value. It does so on the next clock edge and uses the program value from before that edge. A program value of 0 loads 65536: `live_count` reads 0 but the transfer is not complete, and the first byte makes it 0xFFFF.
- R4: Every reload clears `tc_zero`.
- R5: Each cycle with `byte_moved` high during an active DMA command takes one off the live counter. When the counter reaches zero, `tc_zero` is set. The counter never goes below zero. `byte_moved` does nothing while the unit is idle or during a non-DMA command.
- R6: A DMA-in command (`cmd_dir_in`=1, `dma_dir`=1) ends when the live counter is zero. `xfer_done` pulses on the edge after the cycle in which the counter reads zero.
- R7: A DMA-out command (`cmd_dir_in`=0, `dma_dir`=2) ends only when the live counter is zero and `fifo_cnt` is 0.
- R8: A non-DMA command started with `phase_in`=0 ends on the edge after a cycle with `fifo_cnt`=0.
- R9: A non-DMA command started with `phase_in`=1 ends on the edge after a cycle with `fifo_cnt`=1. `phase_in` is sampled when the command is accepted.
- R10: Accepting a DMA command raises `drq` and sets `dma_dir`. Any completion lowers `busy` and `drq`, sets `dma_dir` to 0 (none), and pulses `xfer_done` for one cycle, all on the same edge.
- R11: `cmd_start` while `busy` is high is ignored. The counter, the direction and the running command all stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr_en | input | 2 | Per-byte write enable for the program register |
| cnt_wr_data | input | 8 | Write data byte |
| cmd_start | input | 1 | Command accept strobe |
| cmd_dma | input | 1 | Command uses DMA |
| cmd_dir_in | input | 1 | DMA direction: 1 = into host, 0 = out to bus |
| phase_in | input | 1 | Current bus phase is an input phase |
| byte_moved | input | 1 | One byte moved this cycle |
| fifo_cnt | input | 5 | FIFO occupancy |
| live_count | output | 16 | Live counter value |
| tc_zero | output | 1 | Terminal count reached |
| drq | output | 1 | DMA request |
| dma_dir | output | 2 | 0 none, 1 in, 2 out |
| busy | output | 1 | Command active |
| xfer_done | output | 1 | Completion pulse |

## Verification
Each completion rule is tried in two ways: with a FIFO level that should block completion, and then with the level that should release it. This separates DMA-out from DMA-in, because a zero count alone must not end DMA-out. It also separates the output and input phases of host-driven transfers. A zero program value run for the full 65536 bytes tells the wrapped maximum count apart from an immediate completion. A partial byte-lane write, followed by a reload, shows that the unwritten lane kept its value. A second start issued mid-transfer with a changed program value shows that the running command is not disturbed.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2
  } dma_dir_e;
endpackage

// File: rtl/xfer_prog_reg.sv
module xfer_prog_reg #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W/8-1:0] wr_en,
  input  logic [7:0]         wr_data,
  output logic [CNT_W-1:0]   prog_cnt
);
  localparam int LANES = CNT_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] lane_q, lane_d;
    always_comb begin
      lane_d = lane_q;
      if (wr_en[i]) lane_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end
    assign prog_cnt[8*i +: 8] = lane_q;
  end
endmodule

// File: rtl/xfer_live_ctr.sv
module xfer_live_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] prog_cnt,
  input  logic             dec_en,
  output logic [CNT_W:0]   live_q,
  output logic             live_zero,
  output logic             tc_q
);
  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] MAX_CNT = {1'b1, {CNT_W{1'b0}}};

  logic [FULL_W-1:0] live_d;
  logic              tc_d;

  assign live_zero = (live_q == '0);

  always_comb begin
    live_d = live_q;
    tc_d   = tc_q;
    if (load_en) begin
      live_d = (prog_cnt == '0) ? MAX_CNT : {1'b0, prog_cnt};
      tc_d   = 1'b0;
    end else if (dec_en && !live_zero) begin
      live_d = live_q - 1'b1;
      if (live_d == '0) tc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      tc_q   <= 1'b0;
    end else begin
      live_q <= live_d;
      tc_q   <= tc_d;
    end
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_count_pkg::*;
#(
  parameter int FIFO_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_dma,
  input  logic              cmd_dir_in,
  input  logic              phase_in,
  input  logic              byte_moved,
  input  logic [FIFO_W-1:0] fifo_cnt,
  input  logic              live_zero,
  output logic              load_en,
  output logic              dec_en,
  output logic              busy_q,
  output dma_dir_e          dir_q,
  output logic              drq_q,
  output logic              done_q
);
  localparam logic [FIFO_W-1:0] ONE_BYTE = FIFO_W'(1);

  logic     phase_q, phase_d;
  logic     busy_d, drq_d, done_d;
  dma_dir_e dir_d;
  logic     fifo_empty, end_cond, accept, complete;

  assign fifo_empty = (fifo_cnt == '0);

  always_comb begin
    unique case (dir_q)
      DIR_IN:  end_cond = live_zero;
      DIR_OUT: end_cond = live_zero && fifo_empty;
      default: end_cond = phase_q ? (fifo_cnt == ONE_BYTE) : fifo_empty;
    endcase
  end

  assign accept   = cmd_start && !busy_q;
  assign complete = busy_q && end_cond;
  assign load_en  = accept && cmd_dma;
  assign dec_en   = busy_q && (dir_q != DIR_NONE) && byte_moved && !complete;

  always_comb begin
    busy_d  = busy_q;
    dir_d   = dir_q;
    drq_d   = drq_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    if (complete) begin
      busy_d = 1'b0;
      dir_d  = DIR_NONE;
      drq_d  = 1'b0;
      done_d = 1'b1;
    end else if (accept) begin
      busy_d  = 1'b1;
      phase_d = phase_in;
      drq_d   = cmd_dma;
      dir_d   = !cmd_dma ? DIR_NONE : (cmd_dir_in ? DIR_IN : DIR_OUT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dir_q   <= DIR_NONE;
      drq_q   <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      dir_q   <= dir_d;
      drq_q   <= drq_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/xfer_count_ctl.sv
module xfer_count_ctl
  import xfer_count_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int FIFO_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W/8-1:0] cnt_wr_en,
  input  logic [7:0]         cnt_wr_data,
  input  logic               cmd_start,
  input  logic               cmd_dma,
  input  logic               cmd_dir_in,
  input  logic               phase_in,
  input  logic               byte_moved,
  input  logic [FIFO_W-1:0]  fifo_cnt,
  output logic [CNT_W-1:0]   live_count,
  output logic               tc_zero,
  output logic               drq,
  output logic [1:0]         dma_dir,
  output logic               busy,
  output logic               xfer_done
);
  logic [CNT_W-1:0] prog_cnt;
  logic [CNT_W:0]   live_full;
  logic             live_zero, load_en, dec_en;
  dma_dir_e         dir_q;

  xfer_prog_reg #(.CNT_W(CNT_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .wr_en(cnt_wr_en), .wr_data(cnt_wr_data),
    .prog_cnt(prog_cnt)
  );

  xfer_live_ctr #(.CNT_W(CNT_W)) u_live (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .prog_cnt(prog_cnt),
    .dec_en(dec_en), .live_q(live_full), .live_zero(live_zero), .tc_q(tc_zero)
  );

  xfer_seq #(.FIFO_W(FIFO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_dma(cmd_dma),
    .cmd_dir_in(cmd_dir_in), .phase_in(phase_in), .byte_moved(byte_moved),
    .fifo_cnt(fifo_cnt), .live_zero(live_zero), .load_en(load_en),
    .dec_en(dec_en), .busy_q(busy), .dir_q(dir_q), .drq_q(drq),
    .done_q(xfer_done)
  );

  assign live_count = live_full[CNT_W-1:0];
  assign dma_dir    = dir_q;
endmodule

// File: rtl/xfer_count_chk.sv
module xfer_count_chk #(
  parameter int CNT_W  = 16,
  parameter int FIFO_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              cmd_dma,
  input logic              byte_moved,
  input logic [FIFO_W-1:0] fifo_cnt,
  input logic [CNT_W:0]    live_full,
  input logic              busy,
  input logic [1:0]        dma_dir,
  input logic              drq,
  input logic              tc_zero,
  input logic              xfer_done
);
  // R4
  reload_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_dma && !busy) |=> (!tc_zero && drq));

  // R5
  tc_set_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tc_zero && byte_moved && live_full == 1 && dma_dir != 2'd0)
      |=> (tc_zero && live_full == 0));

  // R5
  hold_without_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_moved) |=> $stable(live_full));

  // R6
  dma_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dma_dir == 2'd1 && live_full == 0) |=> xfer_done);

  // R7
  dma_out_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dma_dir == 2'd2 && fifo_cnt != 0) |=> !xfer_done);

  // R10
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!drq && dma_dir == 2'd0 && !busy));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_start) |=> (xfer_done || dma_dir == $past(dma_dir)));
endmodule

bind xfer_count_ctl xfer_count_chk #(.CNT_W(CNT_W), .FIFO_W(FIFO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_dma(cmd_dma),
  .byte_moved(byte_moved), .fifo_cnt(fifo_cnt), .live_full(live_full),
  .busy(busy), .dma_dir(dma_dir), .drq(drq), .tc_zero(tc_zero),
  .xfer_done(xfer_done)
);

// File: tb/xfer_count_ctl_tb.sv
module xfer_count_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cnt_wr_en = '0;
  logic [7:0] cnt_wr_data = '0;
  logic       cmd_start = 1'b0, cmd_dma = 1'b0, cmd_dir_in = 1'b0;
  logic       phase_in = 1'b0, byte_moved = 1'b0;
  logic [4:0] fifo_cnt = '0;
  logic [15:0] live_count;
  logic       tc_zero, drq, busy, xfer_done;
  logic [1:0] dma_dir;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  xfer_count_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmd_start(cmd_start), .cmd_dma(cmd_dma), .cmd_dir_in(cmd_dir_in),
    .phase_in(phase_in), .byte_moved(byte_moved), .fifo_cnt(fifo_cnt),
    .live_count(live_count), .tc_zero(tc_zero), .drq(drq), .dma_dir(dma_dir),
    .busy(busy), .xfer_done(xfer_done)
  );

  // behavioural reference
  int m_prog, m_live, m_dir;
  bit m_busy, m_tc, m_done, m_dma, m_phase, m_end;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prog = 0; m_live = 0; m_dir = 0; m_busy = 0; m_tc = 0;
      m_done = 0; m_dma = 0; m_phase = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_dma) m_end = (m_live == 0) && (m_dir == 1 || fifo_cnt == 0);
        else       m_end = m_phase ? (fifo_cnt == 1) : (fifo_cnt == 0);
        if (m_end) begin
          m_busy = 0; m_dir = 0; m_done = 1; m_dma = 0;
        end else if (m_dma && byte_moved && m_live > 0) begin
          m_live = m_live - 1;
          if (m_live == 0) m_tc = 1;
        end
      end else if (cmd_start) begin
        m_busy = 1; m_dma = cmd_dma; m_phase = phase_in;
        m_dir = cmd_dma ? (cmd_dir_in ? 1 : 2) : 0;
        if (cmd_dma) begin
          m_live = (m_prog == 0) ? 65536 : m_prog;
          m_tc = 0;
        end
      end
      if (cnt_wr_en[0]) m_prog = (m_prog & 32'hFF00) | cnt_wr_data;
      if (cnt_wr_en[1]) m_prog = (m_prog & 32'h00FF) | (int'(cnt_wr_data) << 8);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 model live_count", 32'(live_count), 32'(m_live & 32'hFFFF));
      chk("R4 model tc_zero", 32'(tc_zero), 32'(m_tc));
      chk("R6 model xfer_done", 32'(xfer_done), 32'(m_done));
      chk("R10 model drq", 32'(drq), 32'(m_dir != 0));
      chk("R10 model dma_dir", 32'(dma_dir), 32'(m_dir));
      chk("R11 model busy", 32'(busy), 32'(m_busy));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] lane, input logic [7:0] d);
    cnt_wr_en = lane; cnt_wr_data = d;
    step();
    cnt_wr_en = '0;
  endtask

  task automatic start(input logic dma, input logic din, input logic ph);
    cmd_start = 1'b1; cmd_dma = dma; cmd_dir_in = din; phase_in = ph;
    step();
    cmd_start = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk("R2 reset live_count", 32'(live_count), 0);
    chk("R10 reset drq", 32'(drq), 0);
    chk("R4 reset tc_zero", 32'(tc_zero), 0);
    chk("R11 reset busy", 32'(busy), 0);

    // DMA in, count 3
    wr(2'b01, 8'h03);
    wr(2'b10, 8'h00);
    chk("R2 write leaves live", 32'(live_count), 0);
    start(1'b1, 1'b1, 1'b0);
    chk("R3 load 3", 32'(live_count), 3);
    chk("R10 drq raised", 32'(drq), 1);
    chk("R10 dir in", 32'(dma_dir), 1);
    byte_moved = 1'b1;
    step(3);
    byte_moved = 1'b0;
    chk("R5 counted to 0", 32'(live_count), 0);
    chk("R5 tc set", 32'(tc_zero), 1);
    chk("R6 not yet done", 32'(xfer_done), 0);
    step();
    chk("R6 dma in done", 32'(xfer_done), 1);
    chk("R10 drq cleared", 32'(drq), 0);
    chk("R10 dir none", 32'(dma_dir), 0);
    byte_moved = 1'b1;
    step(2);
    byte_moved = 1'b0;
    chk("R5 idle byte ignored", 32'(live_count), 0);

    // DMA out, count 2, FIFO holds 3
    wr(2'b01, 8'h02);
    fifo_cnt = 5'd3;
    start(1'b1, 1'b0, 1'b0);
    chk("R4 reload clears tc", 32'(tc_zero), 0);
    chk("R10 dir out", 32'(dma_dir), 2);
    byte_moved = 1'b1;
    step(2);
    byte_moved = 1'b0;
    chk("R5 out counted", 32'(live_count), 0);
    step(4);
    chk("R7 waits on fifo", 32'(busy), 1);
    chk("R7 no done", 32'(xfer_done), 0);
    fifo_cnt = 5'd0;
    step();
    chk("R7 done on fifo empty", 32'(xfer_done), 1);

    // zero program value = 65536
    wr(2'b01, 8'h00);
    start(1'b1, 1'b1, 1'b0);
    chk("R3 zero reads 0", 32'(live_count), 0);
    step();
    chk("R3 zero not done", 32'(xfer_done), 0);
    byte_moved = 1'b1;
    step();
    chk("R3 wrap to FFFF", 32'(live_count), 32'hFFFF);
    step(65535);
    byte_moved = 1'b0;
    chk("R3 full count zero", 32'(live_count), 0);
    chk("R3 full not done", 32'(xfer_done), 0);
    step();
    chk("R3 full done", 32'(xfer_done), 1);

    // non-DMA output phase
    fifo_cnt = 5'd2;
    start(1'b0, 1'b0, 1'b0);
    chk("R10 no drq for pio", 32'(drq), 0);
    byte_moved = 1'b1;
    step(3);
    byte_moved = 1'b0;
    chk("R5 pio byte ignored", 32'(live_count), 0);
    chk("R8 waits", 32'(busy), 1);
    fifo_cnt = 5'd0;
    step();
    chk("R8 done on empty", 32'(xfer_done), 1);

    // non-DMA input phase
    start(1'b0, 1'b0, 1'b1);
    phase_in = 1'b0;
    step(3);
    chk("R9 waits for byte", 32'(busy), 1);
    fifo_cnt = 5'd1;
    step();
    chk("R9 done per byte", 32'(xfer_done), 1);
    fifo_cnt = 5'd0;

    // partial lane write and start while busy
    wr(2'b01, 8'h34);
    wr(2'b10, 8'h12);
    wr(2'b01, 8'h05);
    start(1'b1, 1'b1, 1'b0);
    chk("R1 lanes combine", 32'(live_count), 32'h1205);
    wr(2'b01, 8'h01);
    start(1'b1, 1'b0, 1'b0);
    chk("R11 restart ignored live", 32'(live_count), 32'h1205);
    chk("R11 restart ignored dir", 32'(dma_dir), 1);
    byte_moved = 1'b1;
    step(32'h1205);
    byte_moved = 1'b0;
    step();
    chk("R6 long done", 32'(xfer_done), 1);
    start(1'b1, 1'b1, 1'b0);
    chk("R1 high lane kept", 32'(live_count), 32'h1201);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule